// File: doc/BRIEF.md
# Single-Cycle RV32I Subset Core with Port-Mapped I/O Word

This block is a small processor core that completes one instruction per clock cycle. It runs a subset of the RV32I base integer instructions: word loads and stores, register-register and register-immediate arithmetic and logic, signed set-less-than, equality branch and jump-and-link. The core holds a program counter, a read-only instruction store, a 32-entry register file, an immediate builder, an ALU, a control decoder and a word-addressed data store. The datapath multiplexers and the adder that forms branch and jump targets are part of the core.

The chip sees only four pins: clock, reset, a 32-bit input word and a 32-bit output word. One reserved data address, 0xFFFFFFFC, is not backed by memory. A load from that address returns the input word. A store to it updates the output word. The program is fixed when the core is elaborated, through a parameter array that the integrating level (here, the testbench) fills.

Top module: `rvm_core`

## Requirements
- R1: A high `rst` sampled on a rising clock edge sets the program counter to 0, clears all 32 registers and clears `io_out` to 0. After `rst` falls, the instruction at address 0 executes on the next rising edge.
- R2: Each rising edge out of reset completes exactly one instruction. Addresses are byte addresses, so the instruction store word index is PC[..:2]. When no branch or jump is taken, the PC advances by 4.
- R3: A load word (opcode 0000011, funct3 010) whose effective address is 0xFFFFFFFC writes the current `io_in` value into rd.
- R4: A store word (opcode 0100011, funct3 010) to 0xFFFFFFFC loads rs2 into `io_out` on that edge. `io_out` keeps its value on every other cycle.
- R5: Loads and stores at any other address use the data store word selected by address bits [..:2]. A store there leaves `io_out` unchanged. The S-type offset is {instr[31:25], instr[11:7]}, sign-extended.
- R6: Opcode 0110011 performs add (funct3 000, instr[30]=0), sub (funct3 000, instr[30]=1), slt with signed compare (010), or (110) and and (111). The result is written to rd.
- R7: Opcode 0010011 performs addi (000), slti (010), ori (110) and andi (111). The second operand is the sign-extended instr[31:20].
- R8: beq (opcode 1100011, funct3 000) moves the PC to PC plus the sign-extended B-type offset when rs1 equals rs2. Otherwise the PC moves to PC+4. Backward offsets are supported.
- R9: jal (opcode 1101111) writes PC+4 into rd and moves the PC to PC plus the sign-extended J-type offset.
- R10: Register x0 always reads as 0. Writes that name x0 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| io_in | input | 32 | Word returned by a load from 0xFFFFFFFC |
| io_out | output | 32 | Word written by the last store to 0xFFFFFFFC; 0 after reset |

## Verification
The assertions assume that the program is well formed. Branch and jump offsets must keep the PC word-aligned and inside the instruction store. No load may read a data word that has not yet been stored. The x0 read check also assumes that the rs1 field is decoded on every instruction. The stimulus keeps to these limits: the test program is assembled from encoder functions that use only even offsets that land on real instructions. Every data load is preceded by a store to the same word. The program ends in a jump-to-self. `io_in` changes only at falling edges, so the core never sees it change at a sampling edge.

// File: rtl/rvm_pkg.sv
package rvm_pkg;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_SLT
  } alu_op_e;

  typedef enum logic [1:0] {
    IMM_I,
    IMM_S,
    IMM_B,
    IMM_J
  } imm_fmt_e;

  typedef enum logic [1:0] {
    RES_ALU,
    RES_MEM,
    RES_LINK
  } res_sel_e;

  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_OP     = 7'b0110011;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;

  typedef struct packed {
    logic     reg_we;
    logic     mem_we;
    logic     src_imm;
    logic     branch;
    logic     jump;
    res_sel_e res_sel;
    alu_op_e  alu_op;
    imm_fmt_e imm_fmt;
  } ctrl_t;

endpackage

// File: rtl/rvm_decode.sv
module rvm_decode
  import rvm_pkg::*;
(
  input  logic [31:0] instr,
  output ctrl_t       ctrl,
  output logic [31:0] imm
);

  logic [6:0] opc;
  logic [2:0] f3;
  logic       alt;

  assign opc = instr[6:0];
  assign f3  = instr[14:12];
  assign alt = instr[30];

  function automatic alu_op_e pick_op(input logic [2:0] fn, input logic sub);
    case (fn)
      3'b000:  pick_op = sub ? ALU_SUB : ALU_ADD;
      3'b010:  pick_op = ALU_SLT;
      3'b110:  pick_op = ALU_OR;
      3'b111:  pick_op = ALU_AND;
      default: pick_op = ALU_ADD;
    endcase
  endfunction

  function automatic logic fn_known(input logic [2:0] fn);
    fn_known = (fn == 3'b000) || (fn == 3'b010) || (fn == 3'b110) || (fn == 3'b111);
  endfunction

  always_comb begin
    ctrl         = '0;
    ctrl.alu_op  = ALU_ADD;
    ctrl.imm_fmt = IMM_I;
    ctrl.res_sel = RES_ALU;
    case (opc)
      OPC_LOAD: if (f3 == 3'b010) begin
        ctrl.reg_we  = 1'b1;
        ctrl.src_imm = 1'b1;
        ctrl.res_sel = RES_MEM;
      end
      OPC_STORE: if (f3 == 3'b010) begin
        ctrl.mem_we  = 1'b1;
        ctrl.src_imm = 1'b1;
        ctrl.imm_fmt = IMM_S;
      end
      OPC_OP: begin
        ctrl.alu_op = pick_op(f3, alt);
        ctrl.reg_we = fn_known(f3);
      end
      OPC_OPIMM: begin
        ctrl.alu_op  = pick_op(f3, 1'b0);
        ctrl.src_imm = 1'b1;
        ctrl.reg_we  = fn_known(f3);
      end
      OPC_BRANCH: if (f3 == 3'b000) begin
        ctrl.branch  = 1'b1;
        ctrl.alu_op  = ALU_SUB;
        ctrl.imm_fmt = IMM_B;
      end
      OPC_JAL: begin
        ctrl.jump    = 1'b1;
        ctrl.reg_we  = 1'b1;
        ctrl.res_sel = RES_LINK;
        ctrl.imm_fmt = IMM_J;
      end
      default: ;
    endcase
  end

  always_comb begin
    case (ctrl.imm_fmt)
      IMM_S:   imm = {{20{instr[31]}}, instr[31:25], instr[11:7]};
      IMM_B:   imm = {{19{instr[31]}}, instr[31], instr[7], instr[30:25], instr[11:8], 1'b0};
      IMM_J:   imm = {{11{instr[31]}}, instr[31], instr[19:12], instr[20], instr[30:21], 1'b0};
      default: imm = {{20{instr[31]}}, instr[31:20]};
    endcase
  end

  always_comb begin
    AST_CTRL_EXCLUSIVE: assert ($onehot0({ctrl.branch, ctrl.jump, ctrl.mem_we})); // R8
  end

endmodule

// File: rtl/rvm_alu.sv
module rvm_alu
  import rvm_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  alu_op_e         op,
  output logic [XLEN-1:0] y,
  output logic            zero
);

  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);

  always_comb begin
    if (op == ALU_SUB) begin
      AST_SUB_ZERO_EQ: assert (zero == (a == b)); // R8
    end
  end

endmodule

// File: rtl/rvm_regfile.sv
module rvm_regfile #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [$clog2(NREGS)-1:0] ra1,
  input  logic [$clog2(NREGS)-1:0] ra2,
  input  logic [$clog2(NREGS)-1:0] wa,
  input  logic                     we,
  input  logic [XLEN-1:0]          wd,
  output logic [XLEN-1:0]          rd1,
  output logic [XLEN-1:0]          rd2
);

  localparam int AW = $clog2(NREGS);

  logic [XLEN-1:0]  regs   [1:NREGS-1];
  logic [NREGS-1:1] wen_vec;

  for (genvar g = 1; g < NREGS; g++) begin : g_reg
    assign wen_vec[g] = we && (wa == AW'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        regs[g] <= '0;
      end else if (wen_vec[g]) begin
        regs[g] <= wd;
      end
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

endmodule

// File: rtl/rvm_datamem.sv
module rvm_datamem #(
  parameter int          XLEN    = 32,
  parameter int          WORDS   = 64,
  parameter logic [31:0] IO_ADDR = 32'hFFFF_FFFC
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [31:0]     addr,
  input  logic [XLEN-1:0] wdata,
  input  logic            we,
  output logic [XLEN-1:0] rdata,
  input  logic [XLEN-1:0] io_in,
  output logic [XLEN-1:0] io_out
);

  localparam int AW = $clog2(WORDS);

  logic [XLEN-1:0] mem [WORDS];
  logic [AW-1:0]   idx;
  logic            is_io;
  logic            mem_en;
  logic            io_en;
  logic [XLEN-1:0] io_q;

  assign is_io  = (addr == IO_ADDR);
  assign idx    = addr[AW+1:2];
  assign mem_en = we && !is_io;
  assign io_en  = we && is_io;
  assign rdata  = is_io ? io_in : mem[idx];
  assign io_out = io_q;

  always_ff @(posedge clk) begin
    if (mem_en) begin
      mem[idx] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_q <= '0;
    end else if (io_en) begin
      io_q <= wdata;
    end
  end

  AST_IO_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(we && (addr == IO_ADDR)) |=> $stable(io_out)); // R4

  AST_IO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (we && (addr == IO_ADDR)) |=> (io_out == $past(wdata))); // R4

endmodule

// File: rtl/rvm_core.sv
module rvm_core
  import rvm_pkg::*;
#(
  parameter int          IMEM_WORDS = 64,
  parameter int          DMEM_WORDS = 64,
  parameter logic [31:0] PROG [IMEM_WORDS] = '{default: 32'h0000_0013}
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] io_in,
  output logic [31:0] io_out
);

  localparam int IAW = $clog2(IMEM_WORDS);

  logic [31:0] pc_q;
  logic [31:0] pc_d;
  logic [31:0] instr;
  ctrl_t       ctrl;
  logic [31:0] imm;
  logic [31:0] rs1_val;
  logic [31:0] rs2_val;
  logic [31:0] alu_b;
  logic [31:0] alu_y;
  logic        alu_zero;
  logic [31:0] mem_rd;
  logic [31:0] pc_link;
  logic [31:0] pc_target;
  logic        taken;
  logic [31:0] result;

  assign instr = PROG[pc_q[IAW+1:2]];

  rvm_decode u_decode (
    .instr (instr),
    .ctrl  (ctrl),
    .imm   (imm)
  );

  rvm_regfile #(.XLEN(32), .NREGS(32)) u_regs (
    .clk (clk),
    .rst (rst),
    .ra1 (instr[19:15]),
    .ra2 (instr[24:20]),
    .wa  (instr[11:7]),
    .we  (ctrl.reg_we),
    .wd  (result),
    .rd1 (rs1_val),
    .rd2 (rs2_val)
  );

  assign alu_b = ctrl.src_imm ? imm : rs2_val;

  rvm_alu #(.XLEN(32)) u_alu (
    .a    (rs1_val),
    .b    (alu_b),
    .op   (ctrl.alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  rvm_datamem #(.XLEN(32), .WORDS(DMEM_WORDS)) u_dmem (
    .clk    (clk),
    .rst    (rst),
    .addr   (alu_y),
    .wdata  (rs2_val),
    .we     (ctrl.mem_we),
    .rdata  (mem_rd),
    .io_in  (io_in),
    .io_out (io_out)
  );

  assign pc_link   = pc_q + 32'd4;
  assign pc_target = pc_q + imm;
  assign taken     = ctrl.jump || (ctrl.branch && alu_zero);
  assign pc_d      = taken ? pc_target : pc_link;

  always_comb begin
    case (ctrl.res_sel)
      RES_MEM:  result = mem_rd;
      RES_LINK: result = pc_link;
      default:  result = alu_y;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
    end else begin
      pc_q <= pc_d;
    end
  end

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    !taken |=> (pc_q == $past(pc_q) + 32'd4)); // R2

  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    pc_q[1:0] == 2'b00); // R2

  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
    ctrl.jump |=> (pc_q == $past(pc_q + imm))); // R9

  AST_X0_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (instr[19:15] == 5'd0) |-> (rs1_val == 32'd0)); // R10

endmodule

// File: tb/rvm_core_tb_top.sv
module rvm_core_tb_top;

  typedef logic [31:0] prog_t [64];

  localparam logic [31:0] NOP = 32'h0000_0013;

  function automatic logic [31:0] e_r(input logic [6:0] f7, input int rs2, input int rs1,
                                      input logic [2:0] f3, input int rd);
    e_r = {f7, 5'(rs2), 5'(rs1), f3, 5'(rd), 7'b0110011};
  endfunction

  function automatic logic [31:0] e_i(input int imm, input int rs1, input logic [2:0] f3,
                                      input int rd, input logic [6:0] opc);
    logic [31:0] v = 32'(imm);
    e_i = {v[11:0], 5'(rs1), f3, 5'(rd), opc};
  endfunction

  function automatic logic [31:0] e_s(input int imm, input int rs2, input int rs1);
    logic [31:0] v = 32'(imm);
    e_s = {v[11:5], 5'(rs2), 5'(rs1), 3'b010, v[4:0], 7'b0100011};
  endfunction

  function automatic logic [31:0] e_b(input int imm, input int rs2, input int rs1);
    logic [31:0] v = 32'(imm);
    e_b = {v[12], v[10:5], 5'(rs2), 5'(rs1), 3'b000, v[4:1], v[11], 7'b1100011};
  endfunction

  function automatic logic [31:0] e_j(input int imm, input int rd);
    logic [31:0] v = 32'(imm);
    e_j = {v[20], v[10:1], v[11], v[19:12], 5'(rd), 7'b1101111};
  endfunction

  function automatic prog_t mk_prog();
    prog_t p;
    for (int k = 0; k < 64; k++) p[k] = NOP;
    p[0]  = e_i(5, 0, 3'b000, 1, 7'b0010011);
    p[1]  = e_i(-3, 0, 3'b000, 2, 7'b0010011);
    p[2]  = e_r(7'h00, 2, 1, 3'b000, 3);
    p[3]  = e_s(-4, 3, 0);
    p[4]  = e_r(7'h20, 1, 2, 3'b000, 4);
    p[5]  = e_s(-4, 4, 0);
    p[6]  = e_r(7'h00, 1, 2, 3'b010, 5);
    p[7]  = e_r(7'h00, 2, 1, 3'b010, 6);
    p[8]  = e_r(7'h00, 2, 1, 3'b110, 7);
    p[9]  = e_r(7'h00, 2, 1, 3'b111, 8);
    p[10] = e_s(-4, 5, 0);
    p[11] = e_s(-4, 7, 0);
    p[12] = e_s(-4, 8, 0);
    p[13] = e_i(240, 2, 3'b111, 9, 7'b0010011);
    p[14] = e_i(-16, 1, 3'b110, 10, 7'b0010011);
    p[15] = e_i(-2, 2, 3'b010, 11, 7'b0010011);
    p[16] = e_i(-2, 1, 3'b010, 12, 7'b0010011);
    p[17] = e_s(-4, 9, 0);
    p[18] = e_s(-4, 10, 0);
    p[19] = e_s(-4, 11, 0);
    p[20] = e_s(-4, 12, 0);
    p[21] = e_i(-4, 0, 3'b010, 13, 7'b0000011);
    p[22] = e_s(-4, 13, 0);
    p[23] = e_s(8, 10, 0);
    p[24] = e_s(12, 1, 0);
    p[25] = e_i(8, 0, 3'b010, 14, 7'b0000011);
    p[26] = e_s(-4, 14, 0);
    p[27] = e_i(7, 0, 3'b000, 0, 7'b0010011);
    p[28] = e_s(-4, 0, 0);
    p[29] = e_b(8, 1, 1);
    p[30] = e_s(-4, 1, 0);
    p[31] = e_b(8, 2, 1);
    p[32] = e_s(-4, 2, 0);
    p[33] = e_j(12, 15);
    p[34] = e_s(-4, 1, 0);
    p[35] = e_s(-4, 1, 0);
    p[36] = e_s(-4, 15, 0);
    p[37] = e_i(3, 0, 3'b000, 16, 7'b0010011);
    p[38] = e_i(-1, 16, 3'b000, 16, 7'b0010011);
    p[39] = e_s(-4, 16, 0);
    p[40] = e_b(8, 0, 16);
    p[41] = e_b(-12, 0, 0);
    p[42] = e_i(-4, 0, 3'b010, 17, 7'b0000011);
    p[43] = e_s(-4, 17, 0);
    p[44] = e_j(0, 0);
    return p;
  endfunction

  localparam prog_t TB_PROG = mk_prog();

  function automatic string tag_of(input int idx);
    if (idx <= 1)       tag_of = "R7";
    else if (idx <= 12) tag_of = "R6";
    else if (idx <= 20) tag_of = "R7";
    else if (idx <= 22) tag_of = "R3";
    else if (idx <= 26) tag_of = "R5";
    else if (idx <= 28) tag_of = "R10";
    else if (idx <= 32) tag_of = "R8";
    else if (idx <= 36) tag_of = "R9";
    else if (idx <= 41) tag_of = "R8";
    else if (idx <= 43) tag_of = "R3";
    else                tag_of = "R2";
  endfunction

  logic        clk;
  logic        rst;
  logic [31:0] io_in;
  logic [31:0] io_out;

  rvm_core #(.IMEM_WORDS(64), .DMEM_WORDS(64), .PROG(TB_PROG)) dut_i (
    .clk    (clk),
    .rst    (rst),
    .io_in  (io_in),
    .io_out (io_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Behavioural instruction-set model, one instruction per rising edge
  logic [31:0] m_x   [32];
  logic [31:0] m_mem [64];
  logic [31:0] m_pc;
  logic [31:0] m_out = '0;
  int          m_last = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_pc  = '0;
      m_out = '0;
      for (int k = 0; k < 32; k++) m_x[k] = '0;
      m_last = -1;
    end else begin
      logic [31:0] w, a, b, nxt, val, ea;
      logic        wr;
      int          rd;
      w      = TB_PROG[m_pc[7:2]];
      m_last = int'(m_pc[7:2]);
      a      = m_x[w[19:15]];
      b      = m_x[w[24:20]];
      rd     = int'(w[11:7]);
      nxt    = m_pc + 4;
      wr     = 1'b0;
      val    = '0;
      case (w[6:0])
        7'b0110011: begin
          wr = 1'b1;
          case (w[14:12])
            3'b000: val = w[30] ? a - b : a + b;
            3'b010: val = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            3'b110: val = a | b;
            3'b111: val = a & b;
            default: wr = 1'b0;
          endcase
        end
        7'b0010011: begin
          logic [31:0] iv;
          iv = {{20{w[31]}}, w[31:20]};
          wr = 1'b1;
          case (w[14:12])
            3'b000: val = a + iv;
            3'b010: val = ($signed(a) < $signed(iv)) ? 32'd1 : 32'd0;
            3'b110: val = a | iv;
            3'b111: val = a & iv;
            default: wr = 1'b0;
          endcase
        end
        7'b0000011: begin
          ea  = a + {{20{w[31]}}, w[31:20]};
          val = (ea == 32'hFFFF_FFFC) ? io_in : m_mem[ea[7:2]];
          wr  = 1'b1;
        end
        7'b0100011: begin
          ea = a + {{20{w[31]}}, w[31:25], w[11:7]};
          if (ea == 32'hFFFF_FFFC) m_out = b;
          else m_mem[ea[7:2]] = b;
        end
        7'b1100011: begin
          if (a == b) nxt = m_pc + {{19{w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
        end
        7'b1101111: begin
          val = m_pc + 4;
          wr  = 1'b1;
          nxt = m_pc + {{11{w[31]}}, w[31], w[19:12], w[20], w[30:21], 1'b0};
        end
        default: ;
      endcase
      if (wr && rd != 0) m_x[rd] = val;
      m_pc = nxt;
    end
  end

  int  n_vec  = 0;
  int  n_fail = 0;
  bit  cmp_on = 1'b0;
  bit  done   = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: io_out=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      check((m_last < 0) ? "R1" : tag_of(m_last), io_out, m_out);
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst   = 1'b1;
    io_in = 32'd8;
    run(3);
    check("R1", io_out, 32'd0);
    cmp_on = 1'b1;
    rst    = 1'b0;
    run(20);
    io_in = 32'hCAFE_0001;
    run(40);
    // program now parked in its jump-to-self; last store copied io_in
    check("R3", io_out, 32'hCAFE_0001);
    check("R4", io_out, 32'hCAFE_0001);
    io_in = 32'h1234_5678;
    run(5);
    check("R4", io_out, 32'hCAFE_0001);
    rst = 1'b1;
    run(1);
    check("R1", io_out, 32'd0);
    run(1);
    rst   = 1'b0;
    io_in = 32'h8000_0000;
    run(4);
    check("R6", io_out, 32'd2);
    run(60);
    check("R3", io_out, 32'h8000_0000);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

endmodule